// File: doc/BRIEF.md
# In-Place Exchange Sorter

This block holds `2**L` words of `N` bits in an internal single-port register file and sorts them into ascending order in place. While the run level is low the block is in load mode: the surrounding logic writes words by address and can read any word back with one clock of read latency. Raising the run level starts the sort, which is a nested compare-and-exchange pass.

The sort uses an outer index `i` that steps from the first word to the second-to-last word. For each `i`, a running minimum is read from word `i`. An inner index `j` then walks over every later word. Whenever the running minimum is strictly greater than word `j`, the block does three things in order: it writes word `j`'s value into slot `i`, writes the old minimum into slot `j`, and reloads the running minimum from slot `i`.

When both loops are exhausted, the done flag rises and stays high for as long as run stays high. Dropping run returns the block to load mode, where the sorted words can be read out. The split is a controller state machine steering a datapath of two index counters, two operand registers, a comparator, an address multiplexer and a write-data multiplexer.

Top module: `xs_sorter`

## Requirements
- R1: In load mode (block idle, `run` low), a high `wr_init` at a clock edge stores `wr_data` into the word selected by `addr`.
- R2: In load mode, a high `rd_en` at a clock edge makes `rd_data` show the word at `addr` after that edge. While `rd_en` stays low in load mode, `rd_data` holds its value.
- R3: When `done` rises, word 0 through word `2**L-1` hold the original words in non-decreasing order, with word 0 the smallest.
- R4: An exchange happens only when the running minimum is strictly greater than word `j`. Equal words are never exchanged.
- R5: `done` is low from the start of a sort until the loops finish. It then stays high while `run` is high, and goes low at the first clock edge that samples `run` low.
- R6: `wr_init` has no effect on memory from the edge that starts a sort until the block is back in load mode.
- R7: A low `rst_n` at a clock edge clears `done`, the indices and the controller state, but leaves the stored words unchanged.
- R8: Let `k = 2**L` and let `S` be the number of exchanges that R4 dictates. `done` is first high after clock edge number `2k-1 + 2k(k-1) + 4S`, counting the first edge that samples `run` high as edge 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_data | input | N | Word to store in load mode |
| addr | input | L | Word address for load-mode writes and reads |
| wr_init | input | 1 | Load-mode write strobe |
| run | input | 1 | Level: low selects load mode, high starts and holds a sort |
| rd_en | input | 1 | Load-mode read enable |
| rd_data | output | N | Registered read data |
| done | output | 1 | Sort finished, held while `run` stays high |

## Verification
The exchange count decides the completion time, and that count depends on the data. The hardest cases to reach are runs where the running minimum is replaced several times within one outer pass, and runs with duplicate words, where a wrong comparison would add silent exchanges.

The stimulus covers reversed data, already-sorted data, all-equal data, and random sets drawn from a narrow value range so that duplicates are common. For every set, the bench runs the exchange loop in software to count the exchanges. It then checks `done` against the R8 cycle count on every clock, and checks the final words against the sorted copy.

A reset injected mid-sort, before any write has happened, checks that the stored words survive and that a fresh sort still meets the cycle count.

// File: rtl/xs_pkg.sv
package xs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_I,
        ST_LD_A,
        ST_RD_J,
        ST_LD_B,
        ST_CMP,
        ST_WR_I,
        ST_WR_J,
        ST_RD_A,
        ST_RL_A,
        ST_STEP,
        ST_DONE
    } xs_state_e;

    typedef struct packed {
        logic idle;    // external port owns the memory
        logic clr_i;   // i <= 0
        logic inc_i;   // i <= i + 1
        logic ld_j;    // j <= i + 1
        logic inc_j;   // j <= j + 1
        logic ld_a;    // A <= memory read data
        logic ld_b;    // B <= memory read data
        logic sel_j;   // address from j (else i)
        logic wr_a;    // write data from A (else B)
        logic we;      // internal memory write
        logic re;      // internal memory read
    } xs_ctrl_t;

    function automatic xs_ctrl_t ctrl_none();
        xs_ctrl_t c;
        c = '0;
        return c;
    endfunction

    function automatic logic in_inner_loop(xs_state_e s);
        return s inside {ST_RD_J, ST_LD_B, ST_CMP, ST_WR_I, ST_WR_J,
                         ST_RD_A, ST_RL_A, ST_STEP};
    endfunction

endpackage

// File: rtl/xs_regfile.sv
module xs_regfile #(
    parameter int N = 8,
    parameter int L = 2
) (
    input  logic         clk,
    input  logic         we,
    input  logic         re,
    input  logic [L-1:0] a,
    input  logic [N-1:0] wd,
    output logic [N-1:0] rd
);
    localparam int K = 1 << L;

    logic [N-1:0] mem [K];

    // No reset on the storage: contents survive rst_n.
    always_ff @(posedge clk) begin
        if (we) mem[a] <= wd;
        if (re) rd <= mem[a];
    end
endmodule

// File: rtl/xs_index.sv
module xs_index #(
    parameter int L = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  xs_pkg::xs_ctrl_t ctrl,
    output logic [L-1:0]   i_q,
    output logic [L-1:0]   j_q,
    output logic           zi,
    output logic           zj
);
    localparam int K = 1 << L;
    localparam logic [L-1:0] I_LAST = L'(K - 2);
    localparam logic [L-1:0] J_LAST = L'(K - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            i_q <= '0;
            j_q <= '0;
        end else begin
            if (ctrl.clr_i)      i_q <= '0;
            else if (ctrl.inc_i) i_q <= i_q + 1'b1;
            if (ctrl.ld_j)       j_q <= i_q + 1'b1;
            else if (ctrl.inc_j) j_q <= j_q + 1'b1;
        end
    end

    assign zi = (i_q == I_LAST);
    assign zj = (j_q == J_LAST);
endmodule

// File: rtl/xs_datapath.sv
module xs_datapath #(
    parameter int N = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  xs_pkg::xs_ctrl_t ctrl,
    input  logic [N-1:0]     mem_rd,
    output logic [N-1:0]     a_q,
    output logic [N-1:0]     b_q,
    output logic [N-1:0]     wr_mux,
    output logic             a_gt_b
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else begin
            if (ctrl.ld_a) a_q <= mem_rd;
            if (ctrl.ld_b) b_q <= mem_rd;
        end
    end

    assign wr_mux = ctrl.wr_a ? a_q : b_q;
    assign a_gt_b = (a_q > b_q);
endmodule

// File: rtl/xs_control.sv
module xs_control (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              zi,
    input  logic              zj,
    input  logic              a_gt_b,
    output xs_pkg::xs_ctrl_t  ctrl,
    output xs_pkg::xs_state_e state_q,
    output logic              done
);
    import xs_pkg::*;

    xs_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        ctrl    = ctrl_none();
        unique case (state_q)
            ST_IDLE: begin
                ctrl.idle = 1'b1;
                if (run) begin
                    ctrl.clr_i = 1'b1;
                    state_d    = ST_RD_I;
                end
            end
            ST_RD_I: begin
                ctrl.re = 1'b1;
                state_d = ST_LD_A;
            end
            ST_LD_A: begin
                ctrl.ld_a = 1'b1;
                ctrl.ld_j = 1'b1;
                state_d   = ST_RD_J;
            end
            ST_RD_J: begin
                ctrl.sel_j = 1'b1;
                ctrl.re    = 1'b1;
                state_d    = ST_LD_B;
            end
            ST_LD_B: begin
                ctrl.ld_b = 1'b1;
                state_d   = ST_CMP;
            end
            ST_CMP: begin
                state_d = a_gt_b ? ST_WR_I : ST_STEP;
            end
            ST_WR_I: begin
                ctrl.we = 1'b1;             // Mi <= B
                state_d = ST_WR_J;
            end
            ST_WR_J: begin
                ctrl.sel_j = 1'b1;
                ctrl.wr_a  = 1'b1;
                ctrl.we    = 1'b1;          // Mj <= A
                state_d    = ST_RD_A;
            end
            ST_RD_A: begin
                ctrl.re = 1'b1;             // re-read Mi
                state_d = ST_RL_A;
            end
            ST_RL_A: begin
                ctrl.ld_a = 1'b1;
                state_d   = ST_STEP;
            end
            ST_STEP: begin
                if (!zj) begin
                    ctrl.inc_j = 1'b1;
                    state_d    = ST_RD_J;
                end else if (!zi) begin
                    ctrl.inc_i = 1'b1;
                    state_d    = ST_RD_I;
                end else begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                if (!run) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign done = (state_q == ST_DONE);
endmodule

// File: rtl/xs_sorter.sv
module xs_sorter #(
    parameter int N = 8,
    parameter int L = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] wr_data,
    input  logic [L-1:0] addr,
    input  logic         wr_init,
    input  logic         run,
    input  logic         rd_en,
    output logic [N-1:0] rd_data,
    output logic         done
);
    import xs_pkg::*;

    localparam int K = 1 << L;
    localparam logic [L-1:0] I_LAST = L'(K - 2);

    xs_ctrl_t     ctrl;
    xs_state_e    state_q;
    logic [L-1:0] i_q, j_q;
    logic         zi, zj, a_gt_b;
    logic [N-1:0] a_q, b_q, wr_mux;
    logic         mem_we, mem_re;
    logic [L-1:0] mem_a;
    logic [N-1:0] mem_wd;

    xs_control u_ctrl (
        .clk(clk), .rst_n(rst_n), .run(run), .zi(zi), .zj(zj),
        .a_gt_b(a_gt_b), .ctrl(ctrl), .state_q(state_q), .done(done)
    );

    xs_index #(.L(L)) u_idx (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl),
        .i_q(i_q), .j_q(j_q), .zi(zi), .zj(zj)
    );

    xs_datapath #(.N(N)) u_dp (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .mem_rd(rd_data),
        .a_q(a_q), .b_q(b_q), .wr_mux(wr_mux), .a_gt_b(a_gt_b)
    );

    // Port access only while idle with run low; otherwise the sorter owns it.
    always_comb begin
        if (ctrl.idle) begin
            mem_a  = addr;
            mem_wd = wr_data;
            mem_we = wr_init & ~run;
            mem_re = rd_en;
        end else begin
            mem_a  = ctrl.sel_j ? j_q : i_q;
            mem_wd = wr_mux;
            mem_we = ctrl.we;
            mem_re = ctrl.re;
        end
    end

    xs_regfile #(.N(N), .L(L)) u_mem (
        .clk(clk), .we(mem_we), .re(mem_re), .a(mem_a),
        .wd(mem_wd), .rd(rd_data)
    );

    assert_done_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && run) |=> done);

    assert_done_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !run) |=> !done);

    assert_swap_greater_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WR_I) |-> (a_q > b_q));

    assert_j_beyond_i_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_inner_loop(state_q) |-> (j_q > i_q));

    assert_i_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.idle |-> (i_q <= I_LAST));

    assert_reset_clear_R7: assert property (@(posedge clk)
        !rst_n |=> (!done && state_q == ST_IDLE));
endmodule

// File: tb/xs_sorter_tb.sv
`timescale 1ns/1ps
module xs_sorter_tb;
    localparam int N = 8;
    localparam int L = 2;
    localparam int K = 1 << L;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] wr_data = '0;
    logic [L-1:0] addr = '0;
    logic         wr_init = 1'b0;
    logic         run = 1'b0;
    logic         rd_en = 1'b0;
    logic [N-1:0] rd_data;
    logic         done;

    int n_checks = 0;
    int n_fails  = 0;

    logic [N-1:0] stage [K];   // words loaded into the DUT
    logic [N-1:0] model [K];   // expected final contents
    int           n_swaps;

    always #4 clk = ~clk;      // 125 MHz

    xs_sorter #(.N(N), .L(L)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .addr(addr),
        .wr_init(wr_init), .run(run), .rd_en(rd_en),
        .rd_data(rd_data), .done(done)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    task automatic write_word(input int a, input logic [N-1:0] d);
        @(negedge clk);
        addr = L'(a); wr_data = d; wr_init = 1'b1;
        @(negedge clk);
        wr_init = 1'b0;
    endtask

    task automatic read_word(input int a, output logic [N-1:0] d);
        @(negedge clk);
        addr = L'(a); rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    // Software reference: the exchange loop from R3/R4, counting exchanges.
    task automatic ref_sort();
        logic [N-1:0] amin;
        logic [N-1:0] t;
        n_swaps = 0;
        for (int i = 0; i < K; i++) model[i] = stage[i];
        for (int i = 0; i <= K - 2; i++) begin
            amin = model[i];
            for (int j = i + 1; j <= K - 1; j++) begin
                if (amin > model[j]) begin
                    t = model[j];
                    model[i] = t;
                    model[j] = amin;
                    amin = model[i];
                    n_swaps++;
                end
            end
        end
    endtask

    task automatic load_stage();
        for (int a = 0; a < K; a++) write_word(a, stage[a]);
    endtask

    task automatic readback(input string req);
        logic [N-1:0] d;
        for (int a = 0; a < K; a++) begin
            read_word(a, d);
            check(d === model[a], req, int'(d), int'(model[a]));
        end
    endtask

    // Runs one sort; compares done with the R8 timing on every clock.
    task automatic sort_and_check(input logic intrude);
        int exp_edges;
        int c;
        logic seen;
        ref_sort();
        exp_edges = 2*K - 1 + 2*K*(K-1) + 4*n_swaps;
        @(negedge clk);
        run = 1'b1;
        if (intrude) begin
            wr_init = 1'b1; addr = '0; wr_data = '1;   // R6 attempted overwrite
        end
        seen = 1'b1;
        for (c = 1; c <= exp_edges; c++) begin
            @(negedge clk);
            if (done !== (c == exp_edges)) begin
                seen = 1'b0;
                break;
            end
        end
        check(seen, "R8 done timing", c, exp_edges);
        wr_init = 1'b0;
        repeat (3) @(negedge clk);
        check(done === 1'b1, "R5 done held", int'(done), 1);
        run = 1'b0;
        @(negedge clk);
        check(done === 1'b0, "R5 done release", int'(done), 0);
        readback(intrude ? "R6 result after wr_init attempt" : "R3 sorted contents");
    endtask

    initial begin
        logic [N-1:0] d0, d1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(done === 1'b0, "R7 reset done low", int'(done), 0);

        // R1/R2: write/readback, then hold with rd_en low
        for (int a = 0; a < K; a++) stage[a] = N'(8'h5A + 17*a);
        load_stage();
        for (int a = 0; a < K; a++) model[a] = stage[a];
        readback("R1 R2 load readback");
        read_word(2, d0);
        @(negedge clk); addr = 1; @(negedge clk);
        check(rd_data === d0, "R2 hold with rd_en low", int'(rd_data), int'(d0));

        // R3: fixed example 3,2,4,1
        stage[0] = 3; stage[1] = 2; stage[2] = 4; stage[3] = 1;
        load_stage();
        sort_and_check(1'b0);

        // R4/R8: reversed, sorted, all-equal
        for (int a = 0; a < K; a++) stage[a] = N'(K - a);
        load_stage();
        sort_and_check(1'b0);
        for (int a = 0; a < K; a++) stage[a] = N'(a * 3);
        load_stage();
        sort_and_check(1'b0);
        for (int a = 0; a < K; a++) stage[a] = 8'h77;
        load_stage();
        sort_and_check(1'b0);   // R4 equal words: zero exchanges in timing

        // R3/R4 random sets, narrow range for duplicates
        for (int s = 0; s < 8; s++) begin
            for (int a = 0; a < K; a++)
                stage[a] = (s < 4) ? N'($urandom_range(0, 3)) : N'($urandom);
            load_stage();
            sort_and_check(1'b0);
        end

        // R6: wr_init held high throughout a sort
        stage[0] = 9; stage[1] = 1; stage[2] = 9; stage[3] = 0;
        load_stage();
        sort_and_check(1'b1);

        // R7: reset after sort keeps words
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check(done === 1'b0, "R7 done cleared", int'(done), 0);
        readback("R7 words kept after reset");

        // R7: reset mid-sort before any write, then full sort from scratch
        stage[0] = 200; stage[1] = 100; stage[2] = 50; stage[3] = 25;
        load_stage();
        @(negedge clk); run = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b0; run = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check(done === 1'b0, "R7 mid-sort reset done", int'(done), 0);
        for (int a = 0; a < K; a++) model[a] = stage[a];
        readback("R7 words intact after mid-sort reset");
        sort_and_check(1'b0);

        read_word(0, d1);
        check(d1 === 8'd25, "R3 smallest at word 0", int'(d1), 25);

        finish_run();
    end
endmodule